// File: doc/BRIEF.md
# Bit-Band Alias Read-Modify-Write Unit

This unit sits between one bus master and a 32-bit memory port. The master sees two 32 MB alias windows, one per 1 MB physical region. The default regions are the on-chip RAM area at 0x2000_0000 and the peripheral area at 0x4000_0000. Each window starts 0x0200_0000 above its region. Every bit of a region owns one 32-bit alias word at `region_base + 0x0200_0000 + byte_offset*32 + bit_index*4`.

An access that falls in a window is turned into a single-bit operation on the word that holds the target bit:
- **Alias read:** one memory read, answered with the selected bit in bit 0 and zeros above it.
- **Alias write:** the unit sequences a read, a one-bit merge and a write of the same word on its own. A lock output stays high from the read request until the write is acknowledged, so no other traffic can slip in between.
- **Any other address:** the access passes through unchanged. The request is forwarded one register stage later, and the memory response is returned in the same cycle it arrives.

Both sides use valid/ready requests with one transaction in flight. The memory port returns a single-cycle `mem_rsp_valid_i` for every accepted request, writes included. The master must accept `resp_valid_o` whenever it is raised.

Top module: `bb_alias_rmw`

## Requirements
- R1: While `rst_ni` is low and after its release, `req_ready_o` is 1 and `mem_req_valid_o`, `lock_o` and `resp_valid_o` are 0.
- R2: A request outside both alias windows is presented on the memory port in the cycle after acceptance, with the same address, write flag and write data. Its response data is returned on `resp_rdata_o` in the cycle `mem_rsp_valid_i` is high.
- R3: An alias read issues exactly one memory read, of word `base + {off[24:7],2'b00}`, where `off = addr - (base + 0x0200_0000)`. Its response carries word bit `off[6:2]` in bit 0 and zeros in bits 31:1.
- R4: An alias write reads the target word, then writes it back with only bit `off[6:2]` replaced by bit 0 of the write data. Bits 31:1 of the write data have no effect.
- R5: `lock_o` rises with the read request of an alias write and stays high through the acknowledgement of its write. It is low for pass-through accesses and for alias reads, so an alias write shows exactly two memory handshakes under lock.
- R6: Window decode covers 0x2200_0000–0x23FF_FFFF and 0x4200_0000–0x43FF_FFFF inclusive. The last alias word of a window maps to bit 31 of the region's last word, and addresses just outside a window pass through.
- R7: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address, write flag and write data do not change.
- R8: `req_ready_o` is high only when no transaction is in flight. It drops in the cycle after acceptance and returns in the cycle after the response.
- R9: An alias write answers with `resp_valid_o` one cycle after its write acknowledgement, with `resp_rdata_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Master request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_addr_i | input | 32 | Master byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Master write data |
| resp_valid_o | output | 1 | Response to master valid |
| resp_rdata_o | output | 32 | Response read data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | 32 | Memory word address |
| mem_write_o | output | 1 | Memory write flag |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory response or write acknowledgement |
| mem_rdata_i | input | 32 | Memory read data |
| lock_o | output | 1 | Held during an alias read-modify-write |

## Verification
The bench builds the unit with its default parameters: two regions at 0x2000_0000 and 0x4000_0000, a 1 MB region width and a 0x0200_0000 window offset. This puts the very first and very last alias words of each window in reach, together with their neighbours just outside. Its memory model takes a ready delay, which is first zero for back-to-back timing and then several cycles. The delayed runs exercise the request-hold rule and a read-modify-write whose lock must span the stalls.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PASS_REQ, ST_PASS_RSP, ST_RD_REQ, ST_RD_RSP,
    ST_MODIFY, ST_WR_REQ, ST_WR_RSP, ST_DONE
  } bb_state_e;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] word_addr;
    logic [POS_W-1:0]  pos;
  } bb_dec_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int                               REGION_W    = 20,
  parameter int                               NUM_REGIONS = 2,
  parameter logic [ADDR_W-1:0]                ALIAS_OFS   = 32'h0200_0000,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bb_dec_t           dec_o
);
  localparam int ALIAS_W  = REGION_W + POS_W;  // window = region * bits per word
  localparam int LANE_LSB = POS_W + 2;

  logic [NUM_REGIONS-1:0]             hit;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] waddr;
  logic [NUM_REGIONS-1:0][POS_W-1:0]  pos;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [ADDR_W-1:0] off;
    logic              unused_lsb;
    assign off        = addr_i - (REGION_BASE[g] + ALIAS_OFS);
    assign hit[g]     = (off >> ALIAS_W) == '0;
    assign waddr[g]   = REGION_BASE[g] + ADDR_W'({off[ALIAS_W-1:LANE_LSB], 2'b00});
    assign pos[g]     = off[LANE_LSB-1:2];
    assign unused_lsb = ^off[1:0];
  end

  always_comb begin
    dec_o = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        dec_o.hit       = 1'b1;
        dec_o.word_addr = waddr[i];
        dec_o.pos       = pos[i];
      end
    end
    // R6: windows never overlap
    a_r6_single_window: assert ($onehot0(hit));
  end
endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
  import bb_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              bit_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] word_o
);
  assign bit_o = word_i[pos_i];

  always_comb begin
    word_o        = word_i;
    word_o[pos_i] = bit_i;
  end
endmodule

// File: rtl/bb_alias_rmw.sv
module bb_alias_rmw
  import bb_pkg::*;
#(
  parameter int                               REGION_W    = 20,
  parameter int                               NUM_REGIONS = 2,
  parameter logic [ADDR_W-1:0]                ALIAS_OFS   = 32'h0200_0000,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_write_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              lock_o
);
  bb_state_e         state_q, state_d;
  bb_dec_t           dec;
  logic [ADDR_W-1:0] addr_q, word_q;
  logic [DATA_W-1:0] wdata_q, rword_q, merged;
  logic [POS_W-1:0]  pos_q;
  logic              we_q, nbit_q, sel_bit;

  bb_decode #(
    .REGION_W(REGION_W), .NUM_REGIONS(NUM_REGIONS),
    .ALIAS_OFS(ALIAS_OFS), .REGION_BASE(REGION_BASE)
  ) u_decode (
    .addr_i(req_addr_i),
    .dec_o (dec)
  );

  bb_bitop u_bitop (
    .word_i(rword_q),
    .pos_i (pos_q),
    .bit_i (nbit_q),
    .bit_o (sel_bit),
    .word_o(merged)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i)     state_d = dec.hit ? ST_RD_REQ : ST_PASS_REQ;
      ST_PASS_REQ: if (mem_req_ready_i) state_d = ST_PASS_RSP;
      ST_PASS_RSP: if (mem_rsp_valid_i) state_d = ST_IDLE;
      ST_RD_REQ:   if (mem_req_ready_i) state_d = ST_RD_RSP;
      ST_RD_RSP:   if (mem_rsp_valid_i) state_d = we_q ? ST_MODIFY : ST_DONE;
      ST_MODIFY:                        state_d = ST_WR_REQ;
      ST_WR_REQ:   if (mem_req_ready_i) state_d = ST_WR_RSP;
      ST_WR_RSP:   if (mem_rsp_valid_i) state_d = ST_DONE;
      ST_DONE:                          state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      rword_q <= '0;
      pos_q   <= '0;
      we_q    <= 1'b0;
      nbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        word_q  <= dec.word_addr;
        pos_q   <= dec.pos;
        we_q    <= req_write_i;
        wdata_q <= req_wdata_i;
        nbit_q  <= req_wdata_i[0];
      end
      if (state_q == ST_RD_RSP && mem_rsp_valid_i) rword_q <= mem_rdata_i;
      if (state_q == ST_MODIFY) wdata_q <= merged;
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_PASS_REQ) || (state_q == ST_RD_REQ) ||
                           (state_q == ST_WR_REQ);
  assign mem_addr_o      = (state_q == ST_PASS_REQ) ? addr_q : word_q;
  assign mem_write_o     = ((state_q == ST_PASS_REQ) && we_q) || (state_q == ST_WR_REQ);
  assign mem_wdata_o     = wdata_q;
  assign lock_o          = we_q && ((state_q == ST_RD_REQ) || (state_q == ST_RD_RSP) ||
                           (state_q == ST_MODIFY) || (state_q == ST_WR_REQ) ||
                           (state_q == ST_WR_RSP));
  assign resp_valid_o    = ((state_q == ST_PASS_RSP) && mem_rsp_valid_i) ||
                           (state_q == ST_DONE);
  assign resp_rdata_o    = (state_q == ST_PASS_RSP) ? mem_rdata_i :
                           (we_q ? '0 : DATA_W'(sel_bit));

  a_r5_lock_opens_with_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (mem_req_valid_o && !mem_write_o));

  a_r5_lock_closes_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> ($past(mem_rsp_valid_i) && resp_valid_o));

  a_r4_one_bit_changed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_write_o && lock_o) |-> ($countones(mem_wdata_o ^ rword_q) <= 1));

  a_r7_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o) &&
      $stable(mem_write_o) && $stable(mem_wdata_o)));

  a_r8_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r3_alias_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !mem_rsp_valid_i) |-> (resp_rdata_o[DATA_W-1:1] == '0));
endmodule

// File: tb/bb_alias_rmw_bench.sv
module bb_alias_rmw_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready_o, resp_valid_o, mem_req_valid_o, mem_write_o, lock_o;
  logic [31:0] resp_rdata_o, mem_addr_o, mem_wdata_o;
  logic        mreq_ready, mrsp_valid;
  logic [31:0] mrdata;
  int          stall_n = 0;
  int          wait_q;
  int          hs_cnt, lock_hs_cnt;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;
  logic [31:0] mem_m [logic [31:0]];

  always #5 clk = ~clk;

  bb_alias_rmw u_bb_alias_rmw (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid_o), .resp_rdata_o(resp_rdata_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mreq_ready),
    .mem_addr_o(mem_addr_o), .mem_write_o(mem_write_o), .mem_wdata_o(mem_wdata_o),
    .mem_rsp_valid_i(mrsp_valid), .mem_rdata_i(mrdata), .lock_o(lock_o)
  );

  assign mreq_ready = mem_req_valid_o && (wait_q >= stall_n);

  // memory model: one-cycle response after each handshake
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_m.delete();
      mem_m[32'h3000_0000] = 32'hCAFE_F00D;
      mem_m[32'h2000_0100] = 32'h1234_5678;
      mem_m[32'h4000_0040] = 32'hFFFF_0000;
      wait_q      <= 0;
      mrsp_valid  <= 1'b0;
      mrdata      <= '0;
      hs_cnt      <= 0;
      lock_hs_cnt <= 0;
    end else if (mem_req_valid_o && mreq_ready) begin
      if (mem_write_o) mem_m[mem_addr_o] = mem_wdata_o;
      mrdata      <= mem_m.exists(mem_addr_o) ? mem_m[mem_addr_o] : 32'h0;
      mrsp_valid  <= 1'b1;
      wait_q      <= 0;
      hs_cnt      <= hs_cnt + 1;
      lock_hs_cnt <= lock_hs_cnt + (lock_o ? 1 : 0);
    end else begin
      mrsp_valid <= 1'b0;
      if (mem_req_valid_o) wait_q <= wait_q + 1;
    end
  end

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // kind: 0 pass read, 1 pass write, 2 alias read, 3 alias write
  task automatic run_op(input int kind, input logic [31:0] addr, input logic [31:0] wdata,
                        input logic [31:0] maddr, input logic [31:0] exp, input string tag);
    int hs0, lk0;
    logic [31:0] rd;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_wdata = wdata;
    req_write = (kind == 1) || (kind == 3);
    while (!req_ready_o) @(negedge clk);
    hs0 = hs_cnt; lk0 = lock_hs_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready_o, "R8 busy after accept", 32'(req_ready_o), 32'h0);
    chk(mem_req_valid_o && mem_addr_o == maddr, {tag, " mem address"}, mem_addr_o, maddr);
    while (!resp_valid_o) @(negedge clk);
    rd = resp_rdata_o;
    if (kind == 0 || kind == 2) chk(rd == exp, {tag, " read data"}, rd, exp);
    else chk(mem_rd(maddr) == exp, {tag, " memory word"}, mem_rd(maddr), exp);
    if (kind == 3) chk(rd == 32'h0, "R9 alias write resp", rd, 32'h0);
    chk(lock_hs_cnt - lk0 == ((kind == 3) ? 2 : 0), "R5 locked handshakes",
        32'(lock_hs_cnt - lk0), (kind == 3) ? 32'd2 : 32'd0);
    chk(hs_cnt - hs0 == ((kind == 3) ? 2 : 1), {tag, " handshake count"},
        32'(hs_cnt - hs0), (kind == 3) ? 32'd2 : 32'd1);
    @(negedge clk);
    chk(req_ready_o && !lock_o, "R8 idle after resp", {30'h0, lock_o, req_ready_o}, 32'h1);
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] maddr;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 32'h3000_0000, 32'h0000_0000, 32'h3000_0000, 32'hCAFE_F00D},
    '{2'd1, 32'h3000_0004, 32'h1111_2222, 32'h3000_0004, 32'h1111_2222},
    '{2'd2, 32'h2200_200C, 32'h0000_0000, 32'h2000_0100, 32'h0000_0001},
    '{2'd2, 32'h2200_2020, 32'h0000_0000, 32'h2000_0100, 32'h0000_0000},
    '{2'd3, 32'h2200_207C, 32'h0000_0001, 32'h2000_0100, 32'h9234_5678},
    '{2'd3, 32'h2200_200C, 32'hFFFF_FFFE, 32'h2000_0100, 32'h9234_5670},
    '{2'd3, 32'h4200_0820, 32'h0000_0001, 32'h4000_0040, 32'hFFFF_0100},
    '{2'd2, 32'h4200_087C, 32'h0000_0000, 32'h4000_0040, 32'h0000_0001},
    '{2'd1, 32'h2000_0200, 32'hDEAD_BEEF, 32'h2000_0200, 32'hDEAD_BEEF},
    '{2'd2, 32'h2200_4050, 32'h0000_0000, 32'h2000_0200, 32'h0000_0000}
  };

  function automatic string kind_tag(input int k);
    case (k)
      0, 1:    return "R2 pass-through";
      2:       return "R3 alias read";
      default: return "R4 alias write";
    endcase
  endfunction

  task automatic finish_run;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready_o && !mem_req_valid_o && !lock_o && !resp_valid_o, "R1 in reset",
        {28'h0, resp_valid_o, lock_o, mem_req_valid_o, req_ready_o}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !mem_req_valid_o && !lock_o && !resp_valid_o, "R1 after reset",
        {28'h0, resp_valid_o, lock_o, mem_req_valid_o, req_ready_o}, 32'h1);

    for (int i = 0; i < 10; i++)
      run_op(int'(VECS[i].kind), VECS[i].addr, VECS[i].wdata, VECS[i].maddr, VECS[i].exp,
             kind_tag(int'(VECS[i].kind)));

    // window edges
    run_op(3, 32'h23FF_FFFC, 32'h0000_0001, 32'h200F_FFFC, 32'h8000_0000, "R6 sram last alias");
    run_op(2, 32'h2200_0000, 32'h0, 32'h2000_0000, 32'h0, "R6 sram first alias");
    run_op(0, 32'h2400_0000, 32'h0, 32'h2400_0000, 32'h0, "R6 above sram window");
    run_op(0, 32'h21FF_FFFC, 32'h0, 32'h21FF_FFFC, 32'h0, "R6 below sram window");
    run_op(2, 32'h43FF_FFFC, 32'h0, 32'h400F_FFFC, 32'h0, "R6 peri last alias");
    run_op(1, 32'h4400_0000, 32'h5A5A_5A5A, 32'h4400_0000, 32'h5A5A_5A5A, "R6 above peri window");

    // slow memory
    stall_n = 3;
    run_op(3, 32'h2200_0004, 32'h0000_0001, 32'h2000_0000, 32'h0000_0002, "R7 stalled alias write");
    run_op(2, 32'h2200_0004, 32'h0, 32'h2000_0000, 32'h1, "R7 stalled alias read");
    run_op(0, 32'h3000_0000, 32'h0, 32'h3000_0000, 32'hCAFE_F00D, "R7 stalled pass read");
    run_op(3, 32'h2200_207C, 32'hFFFF_FFFE, 32'h2000_0100, 32'h1234_5670, "R7 stalled alias clear");

    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=%08h exp=%08h", 32'h0, 32'h1);
      finish_run();
    end
  end
endmodule